// File: doc/BRIEF.md
# Timer Count-Clock and Edge Selector

This block sits in front of a 16-bit timer and decides when the timer advances. It holds an 8-bit mode register. The register sets the count source and, for each of two external pins, which transitions count as valid edges. The count source can be the peripheral clock itself, the peripheral clock divided by four, or valid edges seen on pin 0. The block emits a single-cycle count-enable strobe for the counter. It also emits one single-cycle valid-edge strobe per pin, which the capture and clear logic downstream consume.

Both pins are asynchronous to the peripheral clock. Each passes through a two-stage synchronizer before edge detection. The timer control supplies a 2-bit operating mode, and the value 00 means stopped. While the timer runs, the mode register ignores writes.

On the first enable after reset, a pin that is already high is reported once as a rising edge. After a stop and a later restart, no such edge is reported. The timer control also tells the block whether pin-0 edges are in use as a capture trigger or as a clear-and-start trigger. The block flags that use as a configuration error when pin-0 edges are also the count source.

Top module: `timer_clock_select`

## Requirements
- R1: After reset the mode register reads 0x00. Bits 3:2 of the register always read zero, whatever value is written to them.
- R2: A write updates the register on the next clock only when the operating mode is 00. When the mode is nonzero, the write is dropped and the register keeps its value.
- R3: A pin change produces its edge strobe in the second cycle after the pin is sampled. The edge strobe lasts exactly one cycle.
- R4: Each pin's 2-bit edge field is bits 5:4 for pin 0 and bits 7:6 for pin 1. The codes are: 00 = falling edges, 01 = rising edges, 11 = both edges, 10 = no edges at all.
- R5: On the first enable after reset, if a pin is high and its field selects rising or both edges, the block reports exactly one rising edge in the first running cycle.
- R6: After the timer has been stopped and enabled again, a pin that is already high gives no edge strobe.
- R7: With count-source field bits 1:0 = 00, the count enable is high in every running cycle.
- R8: With count-source field 01, the count enable pulses in the fourth running cycle and then in every fourth cycle after it. The divide-by-four phase restarts each time the mode goes to 00.
- R9: With count-source field 11, the count enable pulses exactly when pin 0 gives a valid edge.
- R10: While the operating mode is 00, the count enable and both edge strobes stay low.
- R11: The configuration-error output is high when any field holds code 10. It is also high when the count source is 11 and pin-0 edges are flagged as used for capture or for clear. With count-source code 10, no count enable is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write request |
| wrData | input | 8 | Register write value |
| runMode | input | 2 | Timer operating mode, 00 = stopped |
| captureOnIn0 | input | 1 | Pin-0 edges drive a capture |
| clearOnIn0 | input | 1 | Pin-0 edges drive clear-and-start |
| pinIn0 | input | 1 | Asynchronous external pin 0 |
| pinIn1 | input | 1 | Asynchronous external pin 1 |
| cfgOut | output | 8 | Current mode register value |
| countEn | output | 1 | Single-cycle count-enable strobe |
| edgeIn0 | output | 1 | Pin-0 valid-edge strobe |
| edgeIn1 | output | 1 | Pin-1 valid-edge strobe |
| cfgError | output | 1 | Prohibited or conflicting configuration |

## Verification
Some internal faults are invisible while the pins sit still. A wrong previous-sample value shows up in the first running cycle as a missing or extra edge strobe, which separates the first enable from later ones. A wrong synchronizer depth moves every strobe by a cycle. A divide counter that does not restart shifts the count-enable phase at the next enable, within four cycles. A stale register value shows up at once on the register output and in the decoded strobes, so the bench compares all outputs every cycle against a behavioural model.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int PIN_COUNT = 2;
  localparam int EDGE_BASE = 4;
  localparam logic [7:0] RESERVED_CLEAR = 8'hF3;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    SRC_PCLK = 2'b00,
    SRC_DIV  = 2'b01,
    SRC_NONE = 2'b10,
    SRC_PIN0 = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic running;
    logic writeOk;
    logic trackPrev;
    logic clearDiv;
  } ctl_t;

  typedef struct packed {
    logic [PIN_COUNT-1:0] rise;
    logic [PIN_COUNT-1:0] fall;
    logic                 divTick;
  } evt_t;

endpackage

// File: rtl/tcs_control.sv
module tcs_control
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] runMode,
  input  logic       wrEn,
  output ctl_t       ctl
);

  logic everRun;
  logic running;

  assign running = (runMode != 2'b00);

  // Sticky flag: set once the timer has run at least one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) everRun <= 1'b0;
    else if (running) everRun <= 1'b1;
  end

  always_comb begin
    ctl.running   = running;
    ctl.writeOk   = wrEn & ~running;
    ctl.trackPrev = running | everRun;
    ctl.clearDiv  = ~running;
  end

  // R6: once tracking starts it never stops before the next reset
  assert_track_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.trackPrev |=> ctl.trackPrev)
    else $error("tracking dropped after first run");

endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctl_t                 ctl,
  input  logic [7:0]           wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [7:0]           cfgReg,
  output evt_t                 evt
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [DIV_LOG2-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgReg <= 8'h00;
    else if (ctl.writeOk) cfgReg <= wrData & RESERVED_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else if (ctl.clearDiv) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign evt.divTick = ctl.running && (divCnt == {DIV_LOG2{1'b1}});

  for (genvar p = 0; p < PIN_COUNT; p++) begin : gPin
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevSample;
    logic                   nowSample;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else begin
        chain[0] <= pinIn[p];
        for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
      end
    end

    assign nowSample = chain[SYNC_TOP];

    // Held at zero until the first run, so a high level reads as a rise once.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prevSample <= 1'b0;
      else if (ctl.trackPrev) prevSample <= nowSample;
    end

    assign evt.rise[p] = nowSample & ~prevSample;
    assign evt.fall[p] = ~nowSample & prevSample;

    // R3: an edge event is gone the cycle after it is seen while tracking
    assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.trackPrev && (evt.rise[p] || evt.fall[p])) |=>
        !($past(evt.rise[p]) ? evt.rise[p] : evt.fall[p]))
      else $error("edge event lasted more than one cycle");
  end

  // R2: the register holds its value across any cycle where the timer runs
  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.running |=> $stable(cfgReg))
    else $error("mode register changed while running");

  // R1: reserved bits never read as one
  assert_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfgReg[3:2] == 2'b00)
    else $error("reserved bits set");

endmodule

// File: rtl/tcs_select.sv
module tcs_select
  import tcs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*PIN_COUNT-1:0] edgeCodes,
  input  logic [1:0]             srcCode,
  input  logic                   running,
  input  evt_t                   evt,
  input  logic                   captureOnIn0,
  input  logic                   clearOnIn0,
  output logic [PIN_COUNT-1:0]   edgeOut,
  output logic                   countEn,
  output logic                   cfgError
);

  logic [PIN_COUNT-1:0] badField;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : gDecode
    edge_sel_e code;
    assign code = edge_sel_e'(edgeCodes[2*p +: 2]);

    always_comb begin
      unique case (code)
        EDGE_FALL: edgeOut[p] = running & evt.fall[p];
        EDGE_RISE: edgeOut[p] = running & evt.rise[p];
        EDGE_BOTH: edgeOut[p] = running & (evt.rise[p] | evt.fall[p]);
        default:   edgeOut[p] = 1'b0;
      endcase
      badField[p] = (code == EDGE_NONE);
    end
  end

  src_sel_e src;
  assign src = src_sel_e'(srcCode);

  always_comb begin
    unique case (src)
      SRC_PCLK: countEn = running;
      SRC_DIV:  countEn = running & evt.divTick;
      SRC_PIN0: countEn = edgeOut[0];
      default:  countEn = 1'b0;
    endcase
    cfgError = (|badField) || (src == SRC_NONE) ||
               ((src == SRC_PIN0) && (captureOnIn0 || clearOnIn0));
  end

  // R8: divided enables never come on two cycles in a row
  assert_div_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DIV && countEn) |=> !countEn)
    else $error("divided enable too close");

  // R11: a prohibited source yields an error and no enable
  assert_bad_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NONE) |-> (cfgError && !countEn))
    else $error("prohibited source counted");

endmodule

// File: rtl/timer_clock_select.sv
module timer_clock_select
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic [1:0] runMode,
  input  logic       captureOnIn0,
  input  logic       clearOnIn0,
  input  logic       pinIn0,
  input  logic       pinIn1,
  output logic [7:0] cfgOut,
  output logic       countEn,
  output logic       edgeIn0,
  output logic       edgeIn1,
  output logic       cfgError
);

  ctl_t                 ctl;
  evt_t                 evt;
  logic [7:0]           cfgReg;
  logic [PIN_COUNT-1:0] edgeOut;

  tcs_control uCtl (
    .clk     (clk),
    .rst_n   (rst_n),
    .runMode (runMode),
    .wrEn    (wrEn),
    .ctl     (ctl)
  );

  tcs_datapath #(.SYNC_STAGES(SYNC_STAGES), .DIV_LOG2(DIV_LOG2)) uDp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .wrData (wrData),
    .pinIn  ({pinIn1, pinIn0}),
    .cfgReg (cfgReg),
    .evt    (evt)
  );

  tcs_select uSel (
    .clk          (clk),
    .rst_n        (rst_n),
    .edgeCodes    (cfgReg[EDGE_BASE +: 2*PIN_COUNT]),
    .srcCode      (cfgReg[1:0]),
    .running      (ctl.running),
    .evt          (evt),
    .captureOnIn0 (captureOnIn0),
    .clearOnIn0   (clearOnIn0),
    .edgeOut      (edgeOut),
    .countEn      (countEn),
    .cfgError     (cfgError)
  );

  assign cfgOut  = cfgReg;
  assign edgeIn0 = edgeOut[0];
  assign edgeIn1 = edgeOut[1];

  // R10: a stopped timer emits no strobes
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (runMode == 2'b00) |-> (!countEn && !edgeIn0 && !edgeIn1))
    else $error("strobe while stopped");

endmodule

// File: tb/timer_clock_select_test.sv
module timer_clock_select_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] runMode = 2'b00;
  logic       captureOnIn0 = 1'b0;
  logic       clearOnIn0 = 1'b0;
  logic       pinIn0 = 1'b0;
  logic       pinIn1 = 1'b0;
  logic [7:0] cfgOut;
  logic       countEn, edgeIn0, edgeIn1, cfgError;

  int checks = 0;
  int errors = 0;
  string phaseTag = "R1";

  // reference model state
  bit   mS1 [2];
  bit   mS2 [2];
  bit   mPv [2];
  bit   mEver;
  int   mDiv;
  bit [7:0] mReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_clock_select uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .runMode(runMode),
    .captureOnIn0(captureOnIn0), .clearOnIn0(clearOnIn0),
    .pinIn0(pinIn0), .pinIn1(pinIn1), .cfgOut(cfgOut), .countEn(countEn),
    .edgeIn0(edgeIn0), .edgeIn1(edgeIn1), .cfgError(cfgError));

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phaseTag,
               actual, expected, $time);
    end
  endtask

  function automatic bit expEdge(int p);
    int code = (mReg >> (4 + 2*p)) & 3;
    bit r = mS2[p] && !mPv[p];
    bit f = !mS2[p] && mPv[p];
    if (runMode == 2'b00) return 0;
    if (code == 0) return f;
    if (code == 1) return r;
    if (code == 3) return r || f;
    return 0;
  endfunction

  function automatic bit expCount();
    int src = mReg & 3;
    if (runMode == 2'b00) return 0;
    case (src)
      0: return 1;
      1: return mDiv == 3;
      3: return expEdge(0);
      default: return 0;
    endcase
  endfunction

  function automatic bit expError();
    int src = mReg & 3;
    bit e = (src == 2) || (((mReg >> 4) & 3) == 2) || (((mReg >> 6) & 3) == 2);
    if (src == 3 && (captureOnIn0 || clearOnIn0)) e = 1;
    return e;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < 2; p++) begin mS1[p] = 0; mS2[p] = 0; mPv[p] = 0; end
    mEver = 0; mDiv = 0; mReg = 8'h00;
  endtask

  task automatic cycle();
    bit run;
    bit pins [2];
    #1;
    check("R1 R2 cfgOut", cfgOut, mReg);
    check("R3 R4 edgeIn0", edgeIn0, expEdge(0));
    check("R3 R4 edgeIn1", edgeIn1, expEdge(1));
    check("R7 R8 R9 countEn", countEn, expCount());
    check("R11 cfgError", cfgError, expError());
    @(posedge clk);
    run = (runMode != 2'b00);
    pins[0] = pinIn0; pins[1] = pinIn1;
    if (wrEn && !run) mReg = wrData & 8'hF3;
    for (int p = 0; p < 2; p++) begin
      if (run || mEver) mPv[p] = mS2[p];
      mS2[p] = mS1[p];
      mS1[p] = pins[p];
    end
    mEver = mEver | run;
    mDiv = run ? (mDiv + 1) % 4 : 0;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic writeReg(logic [7:0] v);
    wrEn = 1'b1; wrData = v; cycle(); wrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    phaseTag = "R1";
    check("R1 reset cfgOut", cfgOut, 8'h00);
    check("R1 reset countEn", countEn, 0);
    check("R1 reset edges", {edgeIn1, edgeIn0}, 0);
    check("R1 reset cfgError", cfgError, 0);

    // reserved bits dropped; rising edges on both pins, divided source
    writeReg(8'h5D);
    check("R1 R2 write accepted", cfgOut, 8'h51);

    // pins high before first enable
    phaseTag = "R5";
    pinIn0 = 1'b1; pinIn1 = 1'b1;
    run(4);
    runMode = 2'b01;
    #1 check("R5 first enable reports rise", {edgeIn1, edgeIn0}, 2'b11);
    cycle();
    check("R5 rise reported once", {edgeIn1, edgeIn0}, 2'b00);

    // divided count: first running cycle already passed, count next 7
    phaseTag = "R8";
    n = 0;
    for (int i = 0; i < 7; i++) begin #1 if (countEn) n++; cycle(); end
    check("R8 divided enables in 8 cycles", n, 2);

    phaseTag = "R2";
    writeReg(8'h00);
    check("R2 write locked while running", cfgOut, 8'h51);

    // stop, wiggle pins, restart with pins high
    phaseTag = "R10";
    runMode = 2'b00;
    pinIn0 = 1'b0;
    run(3);
    #1 check("R10 stopped countEn", countEn, 0);
    pinIn0 = 1'b1;
    run(4);
    phaseTag = "R6";
    runMode = 2'b10;
    #1 check("R6 no spurious edge on restart", {edgeIn1, edgeIn0}, 2'b00);
    n = 0;
    for (int i = 0; i < 8; i++) begin #1 if (countEn) n++; cycle(); end
    check("R8 phase restarts after stop", n, 2);

    // pin-0 edges as count source, both-edge fields
    phaseTag = "R9";
    runMode = 2'b00; run(2);
    writeReg(8'hF3);
    check("R11 no conflict without capture", cfgError, 0);
    captureOnIn0 = 1'b1;
    #1 check("R11 capture conflict flagged", cfgError, 1);
    captureOnIn0 = 1'b0; clearOnIn0 = 1'b1;
    #1 check("R11 clear conflict flagged", cfgError, 1);
    clearOnIn0 = 1'b0;
    runMode = 2'b11;
    run(3);
    n = 0;
    for (int t = 0; t < 4; t++) begin
      pinIn0 = ~pinIn0;
      for (int i = 0; i < 3; i++) begin #1 if (countEn) n++; cycle(); end
    end
    for (int i = 0; i < 4; i++) begin #1 if (countEn) n++; cycle(); end
    check("R9 one enable per pin-0 edge", n, 4);

    // falling edges, peripheral clock source; sync latency
    phaseTag = "R7";
    runMode = 2'b00; run(2);
    writeReg(8'h00);
    runMode = 2'b01;
    n = 0;
    for (int i = 0; i < 5; i++) begin #1 if (countEn) n++; cycle(); end
    check("R7 enable every running cycle", n, 5);
    phaseTag = "R3";
    pinIn1 = 1'b1; run(4);
    pinIn1 = 1'b0;
    cycle();
    check("R3 no edge after one sample", edgeIn1, 0);
    cycle();
    check("R3 falling edge second cycle", edgeIn1, 1);
    cycle();
    check("R3 edge lasts one cycle", edgeIn1, 0);

    // prohibited codes
    phaseTag = "R11";
    runMode = 2'b00; run(2);
    writeReg(8'hA2);
    runMode = 2'b01;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      pinIn0 = ~pinIn0; if (i % 2 == 0) pinIn1 = ~pinIn1;
      #1 if (countEn || edgeIn0 || edgeIn1) n++;
      cycle();
    end
    check("R4 R11 prohibited codes silent", n, 0);
    check("R11 prohibited flagged", cfgError, 1);

    // pseudo-random pins under several configurations
    phaseTag = "R4";
    lfsr = 32'h1ACE5;
    foreach (wrData[i]) begin end
    for (int c = 0; c < 6; c++) begin
      runMode = 2'b00; run(2);
      writeReg(8'((c * 8'h45) ^ 8'h11));
      runMode = 2'(1 + c % 3);
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3]) pinIn0 = ~pinIn0;
        if (lfsr[7]) pinIn1 = ~pinIn1;
        wrEn = lfsr[11]; wrData = lfsr[19:12];
        captureOnIn0 = lfsr[20];
        cycle();
      end
      wrEn = 1'b0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule